// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single memory requests from a small processor core into external bus cycles. The bus carries the low address byte and the data on one shared byte-wide port. The core presents one of three request types with a 16-bit address and, for writes, a data byte. The types are an instruction fetch, a data read and a data write. The sequencer then drives the address latch strobe (`ale`), the fetch strobe, the read strobe, the write strobe, the shared port with its output enable, and the high address byte. When the cycle ends it returns one done pulse, together with the byte it captured.

The block runs on a step clock at twice the core rate, so every phase length is a whole number of steps. Two settings set the cycle shape. `cfg_ale_ext` (0 or 1) adds one core clock to the latch pulse. `cfg_wait` (0 to 3) adds core clocks to the strobe. Both settings are taken when a request is accepted. In the requirements, "step" means one period of `clk`, and M and N are the settings latched for the cycle. A request is accepted on the rising edge of `clk` at which both `req_valid` and `req_ready` are high. "Step k" is the k-th full step after that edge, counting from 0.

Top module: `mxb_bus_seq`

## Requirements
- R1: After reset and while idle, `ale` is low and `fetch_n`, `rd_n` and `wr_n` are high. `ad_oe` is low, `req_ready` is high and `rsp_done` is low.
- R2: `ale` is high in steps 0 to 2M, which is 1+2M steps. During these steps the shared port is enabled, it carries address bits [7:0], and all strobes are high.
- R3: Step 1+2M is a single hold step. In it `ale` is low, all strobes are still high, and the port still drives address bits [7:0].
- R4: The strobe is low for exactly 2+2N steps, starting at step 2+2M. `req_kind` picks the strobe: 0 = fetch drives `fetch_n`, 1 or 3 = data read drives `rd_n`, 2 = data write drives `wr_n`. Only one strobe is ever low at a time.
- R5: During a fetch or read strobe, `ad_oe` is low for the whole strobe. During a write strobe, `ad_oe` is high and the port carries the write byte.
- R6: For fetch and read cycles, `rsp_rdata` takes the value that `ad_in` holds in the final strobe step. Values that `ad_in` holds in earlier strobe steps are ignored. A write cycle leaves `rsp_rdata` unchanged.
- R7: After a data read or write strobe rises, two recovery steps follow with `ale` low, all strobes high and `ad_oe` low. A fetch has no recovery steps.
- R8: `rsp_done` is high for one step. For a fetch it comes in the step right after the strobe rises, and for a data cycle it comes right after the recovery steps. `req_ready` is low from acceptance until that done step, and it is high in the done step, where a new request may be accepted.
- R9: Changes to `cfg_ale_ext` or `cfg_wait` after a request is accepted have no effect on the timing of that cycle.
- R10: `addr_hi` shows address bits [15:8] of the accepted request for the whole cycle. It keeps that value after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| cfg_ale_ext | input | 1 | Latch pulse extension M |
| cfg_wait | input | 2 | Strobe wait states N |
| ale | output | 1 | Address latch strobe, active high |
| fetch_n | output | 1 | Instruction fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| addr_hi | output | 8 | High address byte |
| rsp_done | output | 1 | Cycle complete, one step |
| rsp_rdata | output | 8 | Captured read byte |

## Verification
The assertions assume that `rst_n` is asserted from time zero. They also assume that the core holds `req_kind` within its two-bit encoding, which is true by its width. They make no assumption about `req_valid` while the sequencer is busy, because the handshake holds such a request off.

The stimulus changes inputs only at falling clock edges. It raises `req_valid` only in a step where `req_ready` is high, then drops it after one step. It deliberately scrambles the configuration inputs and `ad_in` in the middle of a cycle. This shows that the timing and the captured byte depend only on the latched settings and on the final strobe step.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STROBE,
        ST_RECOVER
    } mxb_state_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ2 = 2'd3
    } mxb_kind_e;

endpackage

// File: rtl/mxb_fsm.sv
module mxb_fsm
    import mxb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_ale_ext,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_ready,
    output mxb_state_e        state,
    output mxb_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int CNT_W = WAIT_W + 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        mxb_state_e        state;
        logic [CNT_W-1:0]  cnt;
        mxb_kind_e         kind;
        logic [WAIT_W-1:0] wait_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.state  = ST_ADDR;
                    seq_d.cnt    = CNT_W'({cfg_ale_ext, 1'b0});
                    seq_d.kind   = mxb_kind_e'(req_kind);
                    seq_d.wait_n = cfg_wait;
                    seq_d.addr   = req_addr;
                    seq_d.wdata  = req_wdata;
                end
            end
            ST_ADDR: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_HOLD;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_ONE;
                end
            end
            ST_HOLD: begin
                seq_d.state = ST_STROBE;
                seq_d.cnt   = CNT_W'({seq_q.wait_n, 1'b1});
            end
            ST_STROBE: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.kind != KIND_WRITE) begin
                        seq_d.rdata = ad_in;
                    end
                    if (seq_q.kind == KIND_FETCH) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.state = ST_RECOVER;
                        seq_d.cnt   = CNT_ONE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_ONE;
                end
            end
            ST_RECOVER: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_ONE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, kind: KIND_FETCH, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == ST_IDLE);
    assign state     = seq_q.state;
    assign kind      = seq_q.kind;
    assign addr      = seq_q.addr;
    assign wdata     = seq_q.wdata;
    assign rsp_done  = seq_q.done;
    assign rsp_rdata = seq_q.rdata;

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
    import mxb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  mxb_state_e        state,
    input  mxb_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale,
    output logic              fetch_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);

    logic addr_phase;
    logic strobing;
    logic is_write;

    always_comb begin
        addr_phase = (state == ST_ADDR) || (state == ST_HOLD);
        strobing   = (state == ST_STROBE);
        is_write   = (kind == KIND_WRITE);

        ale     = (state == ST_ADDR);
        fetch_n = !(strobing && kind == KIND_FETCH);
        rd_n    = !(strobing && (kind == KIND_READ || kind == KIND_READ2));
        wr_n    = !(strobing && is_write);
        ad_oe   = addr_phase || (strobing && is_write);
        ad_out  = addr_phase ? addr[DATA_W-1:0] : wdata;
        addr_hi = addr[ADDR_W-1:DATA_W];
    end

endmodule

// File: rtl/mxb_bus_seq.sv
module mxb_bus_seq
    import mxb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     cfg_ale_ext,
    input  logic [WAIT_W-1:0]        cfg_wait,
    output logic                     ale,
    output logic                     fetch_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata
);

    mxb_state_e        cur_state;
    mxb_kind_e         cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mxb_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_W (WAIT_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .cfg_ale_ext (cfg_ale_ext),
        .cfg_wait    (cfg_wait),
        .ad_in       (ad_in),
        .req_ready   (req_ready),
        .state       (cur_state),
        .kind        (cur_kind),
        .addr        (cur_addr),
        .wdata       (cur_wdata),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata)
    );

    mxb_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_pins (
        .state   (cur_state),
        .kind    (cur_kind),
        .addr    (cur_addr),
        .wdata   (cur_wdata),
        .ale     (ale),
        .fetch_n (fetch_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi)
    );

endmodule

// File: rtl/mxb_bus_seq_chk.sv
module mxb_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic ale,
    input logic fetch_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic rsp_done
);

    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!fetch_n, !rd_n, !wr_n}));

    // R2
    ale_quiet_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && fetch_n && rd_n && wr_n));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && fetch_n && rd_n && wr_n));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !fetch_n) |-> !ad_oe);

    // R7
    data_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (!ale ##1 !ale));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || !fetch_n || !rd_n || !wr_n) |-> !req_ready);

endmodule

bind mxb_bus_seq mxb_bus_seq_chk i_mxb_bus_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .ale       (ale),
    .fetch_n   (fetch_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .rsp_done  (rsp_done)
);

// File: tb/test_mxb_bus_seq.sv
module test_mxb_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        cfg_ale_ext = 1'b0;
    logic [1:0]  cfg_wait = 2'd0;
    logic        ale, fetch_n, rd_n, wr_n, ad_oe, rsp_done;
    logic [7:0]  ad_out, addr_hi, rsp_rdata;
    logic [7:0]  ad_in = 8'h0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = !clk;

    mxb_bus_seq i_mxb_bus_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_kind (req_kind), .req_addr (req_addr), .req_wdata (req_wdata),
        .cfg_ale_ext (cfg_ale_ext), .cfg_wait (cfg_wait),
        .ale (ale), .fetch_n (fetch_n), .rd_n (rd_n), .wr_n (wr_n),
        .ad_out (ad_out), .ad_oe (ad_oe), .ad_in (ad_in),
        .addr_hi (addr_hi), .rsp_done (rsp_done), .rsp_rdata (rsp_rdata)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one full bus cycle starting at a falling edge with the sequencer idle.
    task automatic run_txn(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [7:0] wdata, input bit m, input logic [1:0] n,
                           input bit scramble);
        int a_len = 1 + 2 * int'(m);
        int s_len = 2 + 2 * int'(n);
        int r_len = (kind == 2'd0) ? 0 : 2;
        int last  = a_len + 1 + s_len + r_len;
        logic [7:0] prev = rsp_rdata;
        bit is_fetch = (kind == 2'd0);
        bit is_write = (kind == 2'd2);
        bit is_read  = (kind == 2'd1) || (kind == 2'd3);
        chk("R8 ready before request", 32'(req_ready), 32'd1);
        req_valid   = 1'b1;
        req_kind    = kind;
        req_addr    = addr;
        req_wdata   = wdata;
        cfg_ale_ext = m;
        cfg_wait    = n;
        @(negedge clk);
        req_valid = 1'b0;
        req_kind  = 2'($urandom);
        req_addr  = 16'($urandom);
        if (scramble) begin
            // R9: settings changed after acceptance must not matter
            cfg_ale_ext = 1'($urandom);
            cfg_wait    = 2'($urandom);
        end
        for (int k = 0; k <= last; k++) begin
            bit in_ale  = (k < a_len);
            bit in_hold = (k == a_len);
            bit in_stb  = (k > a_len) && (k <= a_len + s_len);
            bit in_done = (k == last);
            string tag  = in_ale ? "R2" : in_hold ? "R3" : in_stb ? "R4" : in_done ? "R8" : "R7";
            chk(tag, 32'(ale), 32'(in_ale));
            chk(tag, 32'(fetch_n), 32'(!(in_stb && is_fetch)));
            chk(tag, 32'(rd_n), 32'(!(in_stb && is_read)));
            chk(tag, 32'(wr_n), 32'(!(in_stb && is_write)));
            chk(in_stb ? "R5" : tag, 32'(ad_oe), 32'(in_ale || in_hold || (in_stb && is_write)));
            if (in_ale || in_hold) chk(tag, 32'(ad_out), 32'(addr[7:0]));
            if (in_stb && is_write) chk("R5 write data", 32'(ad_out), 32'(wdata));
            chk("R10", 32'(addr_hi), 32'(addr[15:8]));
            chk("R8 ready", 32'(req_ready), 32'(in_done));
            chk("R8 done", 32'(rsp_done), 32'(in_done));
            // R6: only the final strobe step carries the true value
            ad_in = (k == a_len + s_len) ? mem_val(addr) : ~mem_val(addr);
            if (!in_done) @(negedge clk);
        end
        if (is_write) chk("R6 write keeps rdata", 32'(rsp_rdata), 32'(prev));
        else          chk("R6 captured byte", 32'(rsp_rdata), 32'(mem_val(addr)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ale", 32'(ale), 32'd0);
        chk("R1 fetch_n", 32'(fetch_n), 32'd1);
        chk("R1 rd_n", 32'(rd_n), 32'd1);
        chk("R1 wr_n", 32'(wr_n), 32'd1);
        chk("R1 oe", 32'(ad_oe), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(ale), 32'd0);

        // Directed corners: shortest and longest shapes for each kind
        run_txn(2'd0, 16'h1234, 8'h00, 1'b0, 2'd0, 1'b0);
        run_txn(2'd1, 16'hA55A, 8'h00, 1'b0, 2'd0, 1'b0);
        run_txn(2'd2, 16'hFF00, 8'hC3, 1'b0, 2'd0, 1'b0);
        run_txn(2'd3, 16'h00FF, 8'h00, 1'b1, 2'd3, 1'b0);
        run_txn(2'd2, 16'h8001, 8'h3C, 1'b1, 2'd3, 1'b1);
        // Back-to-back fetches with the minimal gap
        run_txn(2'd0, 16'h0100, 8'h00, 1'b1, 2'd1, 1'b1);
        run_txn(2'd0, 16'h0101, 8'h00, 1'b0, 2'd2, 1'b1);

        for (int i = 0; i < 300; i++) begin
            run_txn(2'($urandom), 16'($urandom), 8'($urandom),
                    1'($urandom), 2'($urandom), 1'b1);
            if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule